// File: doc/BRIEF.md
# Page Table Walk Translator

This block turns a 32-bit virtual address into a physical address by fetching one entry from a single-level page table in memory. A requester presents an address and a read/write flag with a valid/ready handshake, together with the base address of the table currently in force. The block forms the entry address from the base and the page number, reads that entry over a simple memory request port, and checks whether the page is present and whether the access is allowed. It then returns either the physical address or a fault code, both through the same response handshake.

When an access is allowed, the block maintains the status bits of the entry itself. Any access sets the used bit, and a write also sets the dirty bit. The updated entry goes back to memory before the response is given, and only if a bit actually changed. A context switch is simply a change of the base input. The value present when a request is accepted governs that whole walk. Only one walk is in flight at a time.

Entry layout: bit 0 present, bit 1 writable, bit 2 used, bit 3 dirty, bits 11:4 carried through unchanged, bits 31:12 frame number. The virtual address is page number in bits 31:12 and offset in bits 11:0.

Top module: `ptw_translator`

## Requirements
- R1: For each accepted request exactly one entry read is issued (mem_req_write = 0) at address table_base + 4 * req_vaddr[31:12], using the table_base value present when the request was accepted.
- R2: When the entry has bit 0 set and the access is permitted, the response carries rsp_fault = 2'b00 and rsp_paddr = {entry[31:12], req_vaddr[11:0]}.
- R3: When entry bit 0 is clear, the response carries rsp_fault = 2'b01 and rsp_paddr = 0, and no entry write-back is issued.
- R4: A write request (req_write = 1) to a present entry with bit 1 clear gets rsp_fault = 2'b10 and rsp_paddr = 0, and no entry write-back is issued.
- R5: A permitted read whose entry has bit 2 clear writes the entry back to the same address with bit 2 set and every other bit unchanged, before the response is delivered.
- R6: A permitted write whose entry lacks bit 2 or bit 3 writes the entry back to the same address with bits 2 and 3 set and every other bit unchanged, before the response is delivered.
- R7: A permitted access that would leave the entry unchanged issues no write-back.
- R8: After reset, req_ready is 1 and rsp_valid and mem_req_valid are 0. From the cycle after a request is accepted until the cycle after its response handshake, req_ready stays 0.
- R9: Changing table_base changes the mapping for the next accepted request, and changes of table_base during a walk do not affect that walk.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid, mem_req_write, mem_req_addr and mem_req_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| table_base | input | 32 | Byte address of the active page table |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 ok, 01 page not present, 10 write to read-only page |
| mem_req_valid | output | 1 | Entry read or write request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Entry read data present, one pulse per read |
| mem_rsp_rdata | input | 32 | Entry read data |

## Verification
The hardest case to reach from the ports is a walk in which every hold and ordering rule is active at once. The entry read stalls, read data comes late, the write-back stalls, and the response then waits on the requester while the table base is already moving. The bench reaches this by driving memory ready, response latency and requester ready from a random pattern. It also scrambles table_base every cycle of a walk. It replays directed entries, including one with the reserved bits set, before it runs a random mix over pages whose status bits change as earlier walks update them. A behavioural memory and a reference model predict each read address, each write-back and each response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned VPN_W     = ADDR_W - OFF_W;
    localparam int unsigned PTE_W     = 32;
    localparam int unsigned PTE_BYTES = PTE_W / 8;
    localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES);
    localparam int unsigned FRAME_W   = ADDR_W - OFF_W;
    localparam int unsigned FLAG_W    = 4;
    localparam int unsigned RSVD_W    = PTE_W - FRAME_W - FLAG_W;

    // Entry layout: frame on top, reserved middle, four flags at the bottom
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               dirty;
        logic               used;
        logic               writable;
        logic               present;
    } pte_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WAIT,
        ST_WB,
        ST_RSP
    } walk_st_e;

    typedef struct packed {
        fault_e            code;
        logic [ADDR_W-1:0] paddr;
        pte_t              upd;
        logic              wb;
    } verdict_t;

    function automatic fault_e classify(input pte_t p, input logic is_wr);
        if (!p.present)
            return FLT_PAGE;
        if (is_wr && !p.writable)
            return FLT_PROT;
        return FLT_NONE;
    endfunction

    function automatic pte_t mark_access(input pte_t p, input logic is_wr);
        pte_t q;
        q      = p;
        q.used = 1'b1;
        if (is_wr)
            q.dirty = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);

    logic [ADDR_W-1:0] vpn_ext;

    always_comb begin
        vpn_ext    = ADDR_W'(vpn);
        entry_addr = base + (vpn_ext << PTE_SHIFT);
    end

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte_word,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output verdict_t         verdict
);

    pte_t   cur;
    pte_t   nxt;
    fault_e code;

    always_comb begin
        cur           = pte_t'(pte_word);
        nxt           = mark_access(cur, is_write);
        code          = classify(cur, is_write);
        verdict.code  = code;
        verdict.upd   = nxt;
        verdict.wb    = (code == FLT_NONE) && (nxt != cur);
        verdict.paddr = (code == FLT_NONE) ? {cur.frame, offset} : '0;
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              lat_write,
    output logic [OFF_W-1:0]  lat_offset,
    input  verdict_t          verdict,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault
);

    walk_st_e st;
    fault_e   fault_q;

    assign req_ready = (st == ST_IDLE);
    assign rsp_fault = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            lat_write     <= 1'b0;
            lat_offset    <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            fault_q       <= FLT_NONE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_write     <= req_write;
                        lat_offset    <= req_offset;
                        mem_req_addr  <= entry_addr;
                        mem_req_write <= 1'b0;
                        mem_req_valid <= 1'b1;
                        st            <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_req_ready) begin
                        mem_req_valid <= 1'b0;
                        st            <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        fault_q   <= verdict.code;
                        rsp_paddr <= verdict.paddr;
                        if (verdict.wb) begin
                            mem_req_valid <= 1'b1;
                            mem_req_write <= 1'b1;
                            mem_req_wdata <= verdict.upd;
                            st            <= ST_WB;
                        end else begin
                            rsp_valid <= 1'b1;
                            st        <= ST_RSP;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_req_ready) begin
                        mem_req_valid <= 1'b0;
                        rsp_valid     <= 1'b1;
                        st            <= ST_RSP;
                    end
                end
                ST_RSP: begin
                    if (rsp_ready) begin
                        rsp_valid <= 1'b0;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst) mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)); // R11
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst) rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) (mem_req_valid || rsp_valid) |-> !req_ready); // R8
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (rst) $rose(mem_req_valid) && mem_req_write |-> $past(mem_rsp_valid)); // R7
    AST_NO_WB_ON_FAULT: assert property (@(posedge clk) disable iff (rst) mem_req_valid && mem_req_write |-> rsp_fault == 2'b00); // R3
    AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (rst) rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0); // R4
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> rsp_fault != 2'b11); // R2
    AST_USED_ON_WB: assert property (@(posedge clk) disable iff (rst) mem_req_valid && mem_req_write |-> mem_req_wdata[2] && mem_req_wdata[0]); // R5
    AST_DIRTY_ON_WR: assert property (@(posedge clk) disable iff (rst) mem_req_valid && mem_req_write && lat_write |-> mem_req_wdata[3] && mem_req_wdata[1]); // R6

endmodule

// File: rtl/ptw_translator.sv
module ptw_translator
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] table_base,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata
);

    logic [ADDR_W-1:0] entry_addr;
    logic              lat_write;
    logic [OFF_W-1:0]  lat_offset;
    verdict_t          verdict;

    ptw_entry_addr u_addr (
        .base       (table_base),
        .vpn        (req_vaddr[ADDR_W-1:OFF_W]),
        .entry_addr (entry_addr)
    );

    ptw_pte_eval u_eval (
        .pte_word (mem_rsp_rdata),
        .is_write (lat_write),
        .offset   (lat_offset),
        .verdict  (verdict)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_offset    (req_vaddr[OFF_W-1:0]),
        .entry_addr    (entry_addr),
        .lat_write     (lat_write),
        .lat_offset    (lat_offset),
        .verdict       (verdict),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault)
    );

endmodule

// File: tb/tb_ptw_translator.sv
`timescale 1ns/1ps
module tb_ptw_translator;

    localparam logic [31:0] BASE_A = 32'h0010_0000;
    localparam logic [31:0] BASE_B = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] table_base = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    ptw_translator dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .table_base(table_base),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    logic [31:0] pmem [logic [31:0]];

    function automatic logic [31:0] mread(input logic [31:0] a);
        if (pmem.exists(a))
            return pmem[a];
        return 32'h0;
    endfunction

    logic [31:0] q_base[$];
    logic [31:0] q_vaddr[$];
    logic        q_wr[$];
    logic        q_r9[$];

    task automatic push_req(input logic [31:0] b, input logic [31:0] v, input logic w, input logic r9);
        q_base.push_back(b);
        q_vaddr.push_back(v);
        q_wr.push_back(w);
        q_r9.push_back(r9);
    endtask

    int checks = 0;
    int failures = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model state
    bit          busy = 0, saw_rd = 0, saw_wb = 0, exp_wb = 0;
    logic [31:0] exp_eaddr, exp_wdata, exp_paddr;
    logic [1:0]  exp_fault;
    string       tag_rsp = "R2", tag_wb = "R7";
    bit          cur_r9 = 0;
    bit          rd_pend = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_data;
    bit          mq_stall = 0, rs_stall = 0;
    logic [31:0] mq_addr, mq_wdata, rs_paddr;
    logic        mq_write;
    logic [1:0]  rs_fault;
    bit          drop_req = 0;
    int          cyc = 0;
    bit          timeout = 0;
    bit          stall_mode = 0;

    task automatic predict(input logic [31:0] b, input logic [31:0] v, input logic w, input logic r9);
        logic [31:0] pte, np;
        exp_eaddr = b + ({12'h0, v[31:12]} * 4);
        pte = mread(exp_eaddr);
        if (!pte[0]) begin
            exp_fault = 2'b01; tag_rsp = "R3";
        end else if (w && !pte[1]) begin
            exp_fault = 2'b10; tag_rsp = "R4";
        end else begin
            exp_fault = 2'b00; tag_rsp = "R2";
        end
        np = pte | 32'h4 | (w ? 32'h8 : 32'h0);
        exp_wb    = (exp_fault == 2'b00) && (np != pte);
        exp_wdata = np;
        exp_paddr = (exp_fault == 2'b00) ? {pte[31:12], v[11:0]} : 32'h0;
        if (exp_fault != 2'b00) tag_wb = tag_rsp;
        else if (exp_wb)        tag_wb = w ? "R6" : "R5";
        else                    tag_wb = "R7";
        if (r9) tag_rsp = "R9";
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) timeout = 1;
        if (!rst) begin
            // compare outputs with the model
            chk(req_ready == !busy, "R8", "req_ready", {31'h0, req_ready}, {31'h0, !busy});
            if (!busy)
                chk(!rsp_valid && !mem_req_valid, "R8", "idle outputs",
                    {30'h0, rsp_valid, mem_req_valid}, 32'h0);
            if (mq_stall)
                chk(mem_req_valid && mem_req_addr == mq_addr && mem_req_write == mq_write &&
                    mem_req_wdata == mq_wdata, "R11", "mem request hold", mem_req_addr, mq_addr);
            if (rs_stall)
                chk(rsp_valid && rsp_paddr == rs_paddr && rsp_fault == rs_fault,
                    "R10", "response hold", rsp_paddr, rs_paddr);
            // drive inputs
            if (drop_req) begin
                req_valid = 1'b0;
                drop_req  = 0;
            end
            if (!req_valid && !busy && q_vaddr.size() > 0 && $urandom_range(0, 2) != 0) begin
                table_base = q_base.pop_front();
                req_vaddr  = q_vaddr.pop_front();
                req_write  = q_wr.pop_front();
                cur_r9     = q_r9.pop_front();
                req_valid  = 1'b1;
            end else if (busy) begin
                table_base = $urandom;
            end
            mem_req_ready = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
            rsp_ready     = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rd_data;
                    rd_pend       = 0;
                end else begin
                    rd_cnt--;
                    mem_rsp_valid = 1'b0;
                end
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_rdata = $urandom;
            end
            // handshakes that the coming rising edge will complete
            mq_stall = mem_req_valid && !mem_req_ready;
            mq_addr  = mem_req_addr;
            mq_write = mem_req_write;
            mq_wdata = mem_req_wdata;
            rs_stall = rsp_valid && !rsp_ready;
            rs_paddr = rsp_paddr;
            rs_fault = rsp_fault;
            if (req_valid && req_ready) begin
                predict(table_base, req_vaddr, req_write, cur_r9);
                busy     = 1;
                saw_rd   = 0;
                saw_wb   = 0;
                drop_req = 1;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (!mem_req_write) begin
                    chk(!saw_rd, "R1", "single entry read", {31'h0, saw_rd}, 32'h0);
                    chk(mem_req_addr == exp_eaddr, cur_r9 ? "R9" : "R1", "entry read address",
                        mem_req_addr, exp_eaddr);
                    saw_rd  = 1;
                    rd_pend = 1;
                    rd_cnt  = stall_mode ? $urandom_range(0, 3) : 0;
                    rd_data = mread(mem_req_addr);
                end else begin
                    chk(exp_wb && saw_rd && !saw_wb, tag_wb, "write-back expected",
                        {31'h0, 1'b1}, {31'h0, exp_wb});
                    chk(mem_req_addr == exp_eaddr, tag_wb, "write-back address",
                        mem_req_addr, exp_eaddr);
                    chk(mem_req_wdata == exp_wdata, tag_wb, "write-back data",
                        mem_req_wdata, exp_wdata);
                    pmem[mem_req_addr] = mem_req_wdata;
                    saw_wb = 1;
                end
            end
            if (rsp_valid && rsp_ready) begin
                chk(busy && saw_rd, "R1", "read before response", {31'h0, saw_rd}, 32'h1);
                chk(rsp_fault == exp_fault, tag_rsp, "fault code", {30'h0, rsp_fault}, {30'h0, exp_fault});
                chk(rsp_paddr == exp_paddr, tag_rsp, "physical address", rsp_paddr, exp_paddr);
                chk(saw_wb == exp_wb, tag_wb, "write-back before response",
                    {31'h0, saw_wb}, {31'h0, exp_wb});
                busy = 0;
            end
        end
    end

    task automatic load_directed();
        pmem.delete();
        pmem[BASE_A + 32'h4]       = 32'h00AA_A001; // present, read-only
        pmem[BASE_A + 32'h8]       = 32'h00BB_B003; // present, writable
        pmem[BASE_A + 32'hC]       = 32'h00CC_C002; // absent
        pmem[BASE_A + 32'h10]      = 32'h00DD_D00F; // all flags set
        pmem[BASE_A + 32'h14]      = 32'h0EEE_EFF1; // reserved bits set
        pmem[BASE_A + 32'h003F_FFFC] = 32'hFFFF_F003; // last page
        pmem[BASE_B + 32'h4]       = 32'h1234_5005; // other table, used
    endtask

    task automatic push_directed();
        push_req(BASE_A, 32'h0000_1ABC, 1'b0, 1'b0); // R5 used set
        push_req(BASE_A, 32'h0000_1ABC, 1'b0, 1'b0); // R7 no change
        push_req(BASE_A, 32'h0000_1ABC, 1'b1, 1'b0); // R4 read-only write
        push_req(BASE_A, 32'h0000_2123, 1'b1, 1'b0); // R6 used and dirty
        push_req(BASE_A, 32'h0000_2FFF, 1'b1, 1'b0); // R7
        push_req(BASE_A, 32'h0000_2000, 1'b0, 1'b0); // R7
        push_req(BASE_A, 32'h0000_3000, 1'b0, 1'b0); // R3
        push_req(BASE_A, 32'h0000_3004, 1'b1, 1'b0); // R3 beats R4
        push_req(BASE_A, 32'h0000_4555, 1'b1, 1'b0); // R7
        push_req(BASE_A, 32'hFFFF_FFFF, 1'b0, 1'b0); // R1 last entry, R5
        push_req(BASE_B, 32'h0000_1ABC, 1'b0, 1'b1); // R9 other mapping
        push_req(BASE_A, 32'h0000_1ABC, 1'b0, 1'b1); // R9 back again
        push_req(BASE_A, 32'h0000_5010, 1'b0, 1'b0); // R5 reserved kept
        push_req(BASE_A, 32'h0077_7000, 1'b1, 1'b0); // R3 unmapped
    endtask

    task automatic drain();
        while (!timeout && (q_vaddr.size() != 0 || busy || req_valid))
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        load_directed();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "reset req_ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R8", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R8", "reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        rst = 1'b0;

        stall_mode = 0;
        push_directed();
        drain();

        stall_mode = 1;
        load_directed();
        push_directed();
        drain();

        for (int v = 6; v <= 12; v++) begin
            pmem[BASE_A + v * 4] = $urandom;
            pmem[BASE_B + v * 4] = $urandom;
        end
        for (int n = 0; n < 250; n++) begin
            logic [19:0] vpn;
            int          pick;
            pick = $urandom_range(0, 14);
            if (pick == 13)      vpn = 20'hFFFFF;
            else if (pick == 14) vpn = 20'h00777;
            else                 vpn = 20'(pick);
            push_req(($urandom_range(0, 1) != 0) ? BASE_A : BASE_B,
                     {vpn, 12'($urandom)}, 1'($urandom), 1'b1);
        end
        drain();

        if (timeout) begin
            failures++;
            $display("FAIL watchdog run did not complete");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule